// File: doc/BRIEF.md
# Comparator Offset Calibration Controller

This block trims the input offset of a rail-to-rail comparator that is built from two halves: one with NMOS input devices and one with PMOS input devices. It works on the N half first and then on the P half. For each half it runs trials. Each trial pulses the comparator into a known reset state. It then lets the comparator resolve with its two inputs tied together, and captures the bit it settles to. A comparator without offset settles to one or zero with equal chance. The controller therefore counts the ones over a window of trials. After each window it either accepts the trim or moves the trim one step so that fewer trials fall on the over-represented side.

The trim for each half is a signed level of small magnitude. It is presented as a side bit and a magnitude, which selects how many calibration devices are switched in on the left or on the right. Calibration of a half ends on a balanced window, or when the trim has hit its end stop and the window still asks for more. In the second case a per-half saturation flag is raised. The inputs stay shorted from the start pulse until both halves are finished. Only then is the short released and done raised.

The sequencer has six states:
- `ST_IDLE`: out of reset.
- `ST_PULSE`: comparator reset, one cycle.
- `ST_SETTLE`: resolution time, `SET_CYC` cycles.
- `ST_SAMPLE`: captures the bit.
- `ST_JUDGE`: window verdict, one cycle.
- `ST_FINISH`: done.

Its transitions are:
- IDLE→PULSE on start.
- PULSE→SETTLE.
- SETTLE→SAMPLE after the settle count.
- SAMPLE→PULSE when more trials remain in the window.
- SAMPLE→JUDGE on the last trial of the window.
- JUDGE→PULSE after a trim step, or when moving from the N half to the P half.
- JUDGE→FINISH when the P half is complete.
- FINISH→PULSE on a new start.

Top module: `cmp_trim_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, done, inputs_short, cmp_reset, type_sel, sat_n and sat_p are 0, and trim_n and trim_p are 3'b000.
- R2: type_sel is 0 while the N half is calibrated and 1 while the P half is calibrated. The N half always comes first. type_sel stays 1 after completion and returns to 0 on the edge that accepts a start.
- R3: Each trial is one cycle of cmp_reset=1, then SET_CYC cycles with cmp_reset=0, then a sample cycle. inputs_short is 1 in every cycle from the accepted start until completion, including every cmp_reset cycle.
- R4: A window is WIN=64 samples. It is balanced when the count of ones k satisfies 32-tol <= k <= 32+tol.
- R5: Each unbalanced window moves the current half's level by exactly one. A window with k > 32+tol decrements the level (toward the left side). A window with k < 32-tol increments it.
- R6: Trim encoding is {side, magnitude[1:0]}. Side 1 means a negative level (left devices) and side 0 means a positive level (right devices). Level 0 is 3'b000, level -3 is 3'b111, level +1 is 3'b001.
- R7: An unbalanced window at level -3 with too many ones, or at level +3 with too few ones, ends that half. The trim is held and that half's sat flag is set.
- R8: A balanced window that arrives when the level is at an end stop ends the half with the sat flag left at 0.
- R9: done and the release of inputs_short come only after both halves finish. With default parameters done is first seen 1 + 257·(total windows) clock edges after the edge that samples start, counting that edge. done stays high until the next start.
- R10: start is ignored while calibration runs. A start in IDLE or FINISH clears both trims and both sat flags and begins again with the N half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (one-cycle pulse) |
| tol | input | TOL_W (5) | Allowed distance of the ones count from half the window |
| cmp_out | input | 1 | Resolved comparator bit |
| cmp_reset | output | 1 | Drives the comparator into its reset state |
| inputs_short | output | 1 | Ties the comparator inputs together |
| type_sel | output | 1 | Half under calibration: 0 = N, 1 = P |
| trim_n | output | MAG_W+1 (3) | N-half trim {side, magnitude} |
| trim_p | output | MAG_W+1 (3) | P-half trim {side, magnitude} |
| sat_n | output | 1 | N-half trim ended at an end stop still unbalanced |
| sat_p | output | 1 | P-half trim ended at an end stop still unbalanced |
| done | output | 1 | Both halves calibrated and inputs released |

## Verification
Two outcomes can be decided in the same JUDGE cycle: a balanced verdict and the level sitting at its end stop. A correct controller must give precedence to the balance and must not flag saturation. This case is provoked with a comparator stream that is all ones for three windows, which drives the N level to -3. The fourth window then carries exactly 32 ones. The run passes when trim_n is 3'b111 with sat_n at 0. A companion run keeps the stream at all ones and expects sat_n to be 1 after the same number of windows. A start pulse that lands in the middle of the P half is judged at the ports. The P half must still finish, and done must appear on the same edge as in an undisturbed run.

// File: rtl/cmp_trim_pkg.sv
`timescale 1ns/1ps
package cmp_trim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PULSE  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_JUDGE  = 3'd4,
        ST_FINISH = 3'd5
    } cal_state_t;

    typedef enum logic [1:0] {
        VERD_BAL  = 2'd0,
        VERD_HIGH = 2'd1,
        VERD_LOW  = 2'd2
    } verdict_t;

    localparam int TYPE_CNT = 2;

endpackage

// File: rtl/cmp_trim_window.sv
`timescale 1ns/1ps
module cmp_trim_window
    import cmp_trim_pkg::*;
#(
    parameter int WIN   = 64,
    parameter int TOL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample_en,
    input  logic             bit_in,
    input  logic [TOL_W-1:0] tol,
    output logic             last,
    output verdict_t         verdict
);

    localparam int IDX_W = $clog2(WIN);
    localparam int CNT_W = $clog2(WIN + 1);
    localparam int SUM_W = ((CNT_W > TOL_W) ? CNT_W : TOL_W) + 1;

    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] ones_q;
    logic [SUM_W-1:0] ones_x;
    logic [SUM_W-1:0] tol_x;
    logic [SUM_W-1:0] half_x;

    assign last = sample_en && (idx_q == IDX_W'(WIN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q  <= '0;
            ones_q <= '0;
        end else if (sample_en) begin
            idx_q  <= last ? '0 : idx_q + 1'b1;
            ones_q <= ones_q + CNT_W'(bit_in);
        end
    end

    always_comb begin
        ones_x  = SUM_W'(ones_q);
        tol_x   = SUM_W'(tol);
        half_x  = SUM_W'(WIN / 2);
        if (ones_x > half_x + tol_x) begin
            verdict = VERD_HIGH;
        end else if (ones_x + tol_x < half_x) begin
            verdict = VERD_LOW;
        end else begin
            verdict = VERD_BAL;
        end
    end

endmodule

// File: rtl/cmp_trim_reg.sv
`timescale 1ns/1ps
module cmp_trim_reg #(
    parameter int MAG_W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step_en,
    input  logic           dir_up,
    input  logic           set_sat,
    output logic [MAG_W:0] code,
    output logic           at_lim,
    output logic           sat
);

    localparam int LVL_W = MAG_W + 1;
    localparam int MAXV  = (1 << MAG_W) - 1;
    localparam logic signed [LVL_W-1:0] LVL_ONE = LVL_W'(1);
    localparam logic signed [LVL_W-1:0] LVL_TOP = LVL_W'(MAXV);
    localparam logic signed [LVL_W-1:0] LVL_BOT = -LVL_TOP;

    logic signed [LVL_W-1:0] lvl_q;
    logic                    sat_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lvl_q <= '0;
            sat_q <= 1'b0;
        end else begin
            if (step_en) begin
                lvl_q <= dir_up ? (lvl_q + LVL_ONE) : (lvl_q - LVL_ONE);
            end
            if (set_sat) begin
                sat_q <= 1'b1;
            end
        end
    end

    always_comb begin
        at_lim = dir_up ? (lvl_q == LVL_TOP) : (lvl_q == LVL_BOT);
        if (lvl_q[LVL_W-1]) begin
            code = {1'b1, MAG_W'(-lvl_q)};
        end else begin
            code = {1'b0, MAG_W'(lvl_q)};
        end
    end

    assign sat = sat_q;

endmodule

// File: rtl/cmp_trim_seq.sv
`timescale 1ns/1ps
module cmp_trim_seq
    import cmp_trim_pkg::*;
#(
    parameter int SET_CYC = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     last,
    input  verdict_t verdict,
    input  logic     at_lim,
    output logic     type_sel,
    output logic     cmp_reset,
    output logic     inputs_short,
    output logic     done,
    output logic     sample_en,
    output logic     win_clear,
    output logic     trim_clear,
    output logic     step_en,
    output logic     dir_up,
    output logic     set_sat
);

    localparam int SET_W = $clog2(SET_CYC + 1);

    cal_state_t       state_q, state_d;
    logic             type_q, type_d;
    logic [SET_W-1:0] set_q, set_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            type_q  <= 1'b0;
            set_q   <= '0;
        end else begin
            state_q <= state_d;
            type_q  <= type_d;
            set_q   <= set_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        type_d  = type_q;
        set_d   = set_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (start) begin
                    state_d = ST_PULSE;
                    type_d  = 1'b0;
                end
            end
            ST_PULSE: begin
                state_d = ST_SETTLE;
                set_d   = '0;
            end
            ST_SETTLE: begin
                if (set_q == SET_W'(SET_CYC - 1)) begin
                    state_d = ST_SAMPLE;
                end else begin
                    set_d = set_q + 1'b1;
                end
            end
            ST_SAMPLE: begin
                state_d = last ? ST_JUDGE : ST_PULSE;
            end
            ST_JUDGE: begin
                state_d = ST_PULSE;
                if (verdict == VERD_BAL || at_lim) begin
                    if (!type_q) begin
                        type_d = 1'b1;
                    end else begin
                        state_d = ST_FINISH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmp_reset    = 1'b0;
        inputs_short = 1'b1;
        done         = 1'b0;
        sample_en    = 1'b0;
        win_clear    = 1'b0;
        trim_clear   = 1'b0;
        step_en      = 1'b0;
        set_sat      = 1'b0;
        dir_up       = (verdict == VERD_LOW);
        type_sel     = type_q;
        unique case (state_q)
            ST_IDLE: begin
                inputs_short = 1'b0;
                win_clear    = start;
                trim_clear   = start;
            end
            ST_FINISH: begin
                inputs_short = 1'b0;
                done         = 1'b1;
                win_clear    = start;
                trim_clear   = start;
            end
            ST_PULSE:  cmp_reset = 1'b1;
            ST_SETTLE: ;
            ST_SAMPLE: sample_en = 1'b1;
            ST_JUDGE: begin
                win_clear = 1'b1;
                step_en   = (verdict != VERD_BAL) && !at_lim;
                set_sat   = (verdict != VERD_BAL) && at_lim;
            end
            default: inputs_short = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmp_trim_ctrl.sv
`timescale 1ns/1ps
module cmp_trim_ctrl
    import cmp_trim_pkg::*;
#(
    parameter int WIN     = 64,
    parameter int TOL_W   = 5,
    parameter int MAG_W   = 2,
    parameter int SET_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TOL_W-1:0] tol,
    input  logic             cmp_out,
    output logic             cmp_reset,
    output logic             inputs_short,
    output logic             type_sel,
    output logic [MAG_W:0]   trim_n,
    output logic [MAG_W:0]   trim_p,
    output logic             sat_n,
    output logic             sat_p,
    output logic             done
);

    logic     last, sample_en, win_clear, trim_clear;
    logic     step_en, dir_up, set_sat, at_lim;
    verdict_t verdict;

    logic [MAG_W:0]      code_a [TYPE_CNT];
    logic [TYPE_CNT-1:0] lim_a;
    logic [TYPE_CNT-1:0] sat_a;

    cmp_trim_window #(.WIN(WIN), .TOL_W(TOL_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (win_clear),
        .sample_en (sample_en),
        .bit_in    (cmp_out),
        .tol       (tol),
        .last      (last),
        .verdict   (verdict)
    );

    cmp_trim_seq #(.SET_CYC(SET_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .last         (last),
        .verdict      (verdict),
        .at_lim       (at_lim),
        .type_sel     (type_sel),
        .cmp_reset    (cmp_reset),
        .inputs_short (inputs_short),
        .done         (done),
        .sample_en    (sample_en),
        .win_clear    (win_clear),
        .trim_clear   (trim_clear),
        .step_en      (step_en),
        .dir_up       (dir_up),
        .set_sat      (set_sat)
    );

    for (genvar g = 0; g < TYPE_CNT; g++) begin : g_half
        cmp_trim_reg #(.MAG_W(MAG_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (trim_clear),
            .step_en (step_en && (type_sel == 1'(g))),
            .dir_up  (dir_up),
            .set_sat (set_sat && (type_sel == 1'(g))),
            .code    (code_a[g]),
            .at_lim  (lim_a[g]),
            .sat     (sat_a[g])
        );
    end

    assign at_lim = lim_a[type_sel];
    assign trim_n = code_a[0];
    assign trim_p = code_a[1];
    assign sat_n  = sat_a[0];
    assign sat_p  = sat_a[1];

endmodule

// File: rtl/cmp_trim_ctrl_props.sv
`timescale 1ns/1ps
module cmp_trim_ctrl_props #(
    parameter int MAG_W = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           cmp_reset,
    input logic           inputs_short,
    input logic           type_sel,
    input logic [MAG_W:0] trim_n,
    input logic [MAG_W:0] trim_p,
    input logic           sat_n,
    input logic           sat_p,
    input logic           done
);

    function automatic int lvl(input logic [MAG_W:0] c);
        return c[MAG_W] ? -int'(c[MAG_W-1:0]) : int'(c[MAG_W-1:0]);
    endfunction

    assert_short_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_reset |-> inputs_short);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_reset |=> !cmp_reset);

    assert_release_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!inputs_short && !cmp_reset));

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_step_n_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inputs_short && $past(inputs_short)) |->
        ((lvl(trim_n) == lvl($past(trim_n))) ||
         (lvl(trim_n) == lvl($past(trim_n)) + 1) ||
         (lvl(trim_n) == lvl($past(trim_n)) - 1)));

    assert_step_p_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inputs_short && $past(inputs_short)) |->
        ((lvl(trim_p) == lvl($past(trim_p))) ||
         (lvl(trim_p) == lvl($past(trim_p)) + 1) ||
         (lvl(trim_p) == lvl($past(trim_p)) - 1)));

    assert_p_after_n_R2: assert property (@(posedge clk) disable iff (!rst_n)
        type_sel |-> $stable(trim_n) || !$past(inputs_short) || !inputs_short);

    assert_type_back_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(type_sel) |-> !$past(inputs_short));

    assert_sat_n_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_n && $past(sat_n)) |-> $stable(trim_n));

    assert_sat_p_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_p && $past(sat_p)) |-> $stable(trim_p));

endmodule

bind cmp_trim_ctrl cmp_trim_ctrl_props #(.MAG_W(MAG_W)) u_props (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cmp_reset    (cmp_reset),
    .inputs_short (inputs_short),
    .type_sel     (type_sel),
    .trim_n       (trim_n),
    .trim_p       (trim_p),
    .sat_n        (sat_n),
    .sat_p        (sat_p),
    .done         (done)
);

// File: tb/cmp_trim_ctrl_test.sv
`timescale 1ns/1ps
module cmp_trim_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] tol = 5'd0;
    logic       cmp_out = 1'b0;
    logic       cmp_reset, inputs_short, type_sel, sat_n, sat_p, done;
    logic [2:0] trim_n, trim_p;

    always #4 clk = ~clk;

    cmp_trim_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .tol          (tol),
        .cmp_out      (cmp_out),
        .cmp_reset    (cmp_reset),
        .inputs_short (inputs_short),
        .type_sel     (type_sel),
        .trim_n       (trim_n),
        .trim_p       (trim_p),
        .sat_n        (sat_n),
        .sat_p        (sat_p),
        .done         (done)
    );

    int n_run = 0;
    int n_fail = 0;
    int kn [16];
    int kp [16];
    int mode = 0;
    int off_n = 0;
    int off_p = 0;
    logic [15:0] lfsr = 16'hACE1;
    int idx = 0;
    logic prev_type = 1'b0;
    int cyc = 0;

    function automatic int lvl_of(input logic [2:0] c);
        return c[2] ? -int'(c[1:0]) : int'(c[1:0]);
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // comparator model: trial bits driven while cmp_reset is seen high
    always @(negedge clk) begin
        int w, k, v, nz;
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
        if (!inputs_short || type_sel != prev_type) idx = 0;
        prev_type = type_sel;
        if (cmp_reset) begin
            w = idx / 64;
            if (w > 15) w = 15;
            if (mode == 0) begin
                k = type_sel ? kp[w] : kn[w];
                cmp_out = ((idx % 64) < k);
            end else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                nz = int'(lfsr[5:0]) - 32;
                v = (type_sel ? off_p : off_n)
                    + 24 * (type_sel ? lvl_of(trim_p) : lvl_of(trim_n)) + nz;
                cmp_out = (v > 0);
            end
            idx++;
        end
    end

    task automatic set_k(input int a0, a1, a2, a3, input int b0, b1);
        for (int i = 0; i < 16; i++) begin
            kn[i] = (i == 0) ? a0 : (i == 1) ? a1 : (i == 2) ? a2 : a3;
            kp[i] = (i == 0) ? b0 : b1;
        end
    endtask

    task automatic run_cal(input int mid, output int cyc_n, output logic t100,
                           output logic t300, output logic s100, output logic d100);
        int n;
        t100 = 1'b0; t300 = 1'b0; s100 = 1'b0; d100 = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; n = 1;
        while (!done && n < 20000) begin
            if (n == 100) begin t100 = type_sel; s100 = inputs_short; d100 = done; end
            if (n == 300) t300 = type_sel;
            start = (n == mid);
            @(negedge clk); n++;
        end
        start = 1'b0;
        cyc_n = n;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 done in reset", done, 0);
        check_eq("R1 short in reset", inputs_short, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 cmp_reset", cmp_reset, 0);
        check_eq("R1 type_sel", type_sel, 0);
        check_eq("R1 trim_n", trim_n, 0);
        check_eq("R1 trim_p", trim_p, 0);
        check_eq("R1 sat flags", {sat_n, sat_p}, 0);
    endtask

    task automatic t_saturate_left;
        int c; logic a, b, s, d;
        mode = 0; tol = 5'd0; set_k(64, 64, 64, 64, 32, 32);
        run_cal(0, c, a, b, s, d);
        check_eq("R7 trim_n end stop left", trim_n, 7);
        check_eq("R7 sat_n set", sat_n, 1);
        check_eq("R4 trim_p balanced", trim_p, 0);
        check_eq("R4 sat_p clear", sat_p, 0);
        check_eq("R9 cycles 5 windows", c, 1286);
    endtask

    task automatic t_saturate_right;
        int c; logic a, b, s, d;
        mode = 0; tol = 5'd3; set_k(0, 0, 0, 0, 0, 0);
        run_cal(0, c, a, b, s, d);
        check_eq("R7 trim_n end stop right", trim_n, 3);
        check_eq("R7 trim_p end stop right", trim_p, 3);
        check_eq("R7 both sat", {sat_n, sat_p}, 3);
        check_eq("R9 cycles 8 windows", c, 2057);
    endtask

    task automatic t_balanced_restart;
        int c; logic a, b, s, d;
        mode = 0; tol = 5'd0; set_k(32, 32, 32, 32, 32, 32);
        run_cal(0, c, a, b, s, d);
        check_eq("R10 restart clears sat", {sat_n, sat_p}, 0);
        check_eq("R4 exact half trim_n", trim_n, 0);
        check_eq("R4 exact half trim_p", trim_p, 0);
        check_eq("R9 cycles 2 windows", c, 515);
        check_eq("R2 N first", a, 0);
        check_eq("R2 P second", b, 1);
        check_eq("R3 short held mid-run", s, 1);
        check_eq("R9 no early done", d, 0);
        check_eq("R9 short released", inputs_short, 0);
        check_eq("R2 type stays P at finish", type_sel, 1);
    endtask

    task automatic t_limit_coincide;
        int c; logic a, b, s, d;
        mode = 0; tol = 5'd0; set_k(64, 64, 64, 32, 32, 32);
        run_cal(0, c, a, b, s, d);
        check_eq("R8 trim_n at end stop", trim_n, 7);
        check_eq("R8 sat_n stays 0", sat_n, 0);
        check_eq("R8 cycles", c, 1286);
    endtask

    task automatic t_tolerance_edge;
        int c; logic a, b, s, d;
        mode = 0; tol = 5'd5; set_k(38, 37, 37, 37, 26, 27);
        run_cal(0, c, a, b, s, d);
        check_eq("R5 one step left trim_n", trim_n, 5);
        check_eq("R6 one step right trim_p", trim_p, 1);
        check_eq("R4 edge windows count", c, 1029);
    endtask

    task automatic t_noisy;
        int c; logic a, b, s, d;
        mode = 1; tol = 5'd12; off_n = 48; off_p = -24;
        run_cal(0, c, a, b, s, d);
        check_eq("R5 noisy trim_n level -2", trim_n, 6);
        check_eq("R5 noisy trim_p level +1", trim_p, 1);
        check_eq("R7 noisy no sat", {sat_n, sat_p}, 0);
        mode = 0;
    endtask

    task automatic t_start_busy;
        int c; logic a, b, s, d;
        mode = 0; tol = 5'd0; set_k(32, 32, 32, 32, 32, 32);
        run_cal(300, c, a, b, s, d);
        check_eq("R10 busy start ignored cycles", c, 515);
        check_eq("R10 busy start type kept", type_sel, 1);
        check_eq("R10 busy start done", done, 1);
    endtask

    initial begin
        t_reset();
        t_saturate_left();
        t_saturate_right();
        t_balanced_restart();
        t_limit_coincide();
        t_tolerance_edge();
        t_noisy();
        t_start_busy();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule